// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the finite-state controller of a 32-bit RISC core that runs each instruction over several clock cycles on one shared datapath: a single memory for code and data, a single ALU and a handful of holding registers. It reads the opcode and, for register-to-register operations, the function field of the instruction register. From these it drives every select and write-enable line of that datapath for the current step. The registers, the memory and the ALU themselves sit outside the block.

Every instruction starts with two common steps: fetch, then decode. Depending on the opcode it then takes one to three more steps. Branches and jumps finish after three steps. Register operations and stores finish after four. Loads finish after five. The reserved all-ones opcode parks the controller in a halt state after decode. From there only reset brings it back.

All outputs are decoded from the current state. The ALU operation is the only exception: in the register-operation steps it also depends on the function field. The branch comparison itself is done by the datapath. The controller raises the conditional PC write and says whether the branch is taken on equality or on inequality.

Top module: `mcyc_control`

## Requirements
- R1: In the fetch step the controller drives addr_sel=0, mem_rd=1, ir_wr=1, alu_a_sel=0, alu_b_sel=01, alu_op=010 (add), pc_src=00 and pc_wr=1. All other enables are 0.
- R2: In the decode step it drives alu_a_sel=0, alu_b_sel=11 and alu_op=010, with every write enable and mem_rd at 0. The step after decode is chosen by the opcode: 000000 register operation, 100011 load, 101011 store, 000100 branch-if-equal, 000101 branch-if-not-equal, 000010 jump, 111111 halt.
- R3: For a register operation the execute step drives alu_a_sel=1 and alu_b_sel=00. The step after it drives reg_wr=1, dst_sel=1 and wb_sel=0, and then fetch follows. In both steps alu_op follows the function field: 0x20 gives 010 (add), 0x22 gives 110 (sub), 0x24 gives 000 (and), 0x25 gives 001 (or), 0x27 gives 100 (nor), 0x2A gives 111 (set-less-than).
- R4: For a load or a store, the execute step drives alu_a_sel=1, alu_b_sel=10 and alu_op=010, with no writes.
- R5: A load then reads memory with addr_sel=1 and mem_rd=1. Next it writes the register file with reg_wr=1, dst_sel=0 and wb_sel=1. Then fetch follows.
- R6: A store then writes memory with addr_sel=1 and mem_wr=1. Then fetch follows.
- R7: For branch-if-equal, the execute step drives alu_a_sel=1, alu_b_sel=00, alu_op=110, pc_wr_cond=1, br_ne=0 and pc_src=01. Then fetch follows.
- R8: For branch-if-not-equal, the execute step matches R7 except that br_ne=1.
- R9: For a jump, the execute step drives pc_wr=1 and pc_src=10 (PC upper four bits joined with the 26-bit target and two zero bits). Then fetch follows.
- R10: After decode of opcode 111111 the controller stays halted whatever the opcode and function inputs do. While halted, mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond and reg_wr are all 0.
- R11: Reset is synchronous and active high. While rst=1 all write enables are 0. The first cycle after reset is a fetch step.
- R12: Any opcode not listed in R2 returns to fetch right after decode, with no writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALUOut |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC load |
| pc_wr_cond | output | 1 | PC load subject to the branch condition |
| br_ne | output | 1 | Branch condition polarity: 0 equal, 1 not equal |
| alu_a_sel | output | 1 | ALU input A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU input B: 00 register B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 3 | ALU operation code |
| dst_sel | output | 1 | Destination register field: 0 bits 20:16, 1 bits 15:11 |
| wb_sel | output | 1 | Register write data: 0 ALUOut, 1 MDR |
| reg_wr | output | 1 | Register file write enable |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALUOut, 10 jump target |

## Verification
The case hardest to reach from the ports is the halt state. Nothing marks it from outside. It can only be told apart from a stuck or looping controller by the absence of any write enable over many cycles. The stimulus decodes the all-ones opcode and then holds the controller for a long stretch. During that stretch it presents every other opcode and function code and expects all-quiet outputs on each cycle. It then leaves the halt only through reset and runs a normal instruction again. The function field is also changed between the execute and completion steps of register operations, which shows that alu_op follows the field live.

// File: rtl/mcyc_control.sv
module mcyc_control (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       addr_sel,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_wr,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic       br_ne,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [2:0] alu_op,
  output logic       dst_sel,
  output logic       wb_sel,
  output logic       reg_wr,
  output logic [1:0] pc_src
);

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_JUMP  = 6'b000010;
  localparam logic [5:0] OP_HALT  = 6'b111111;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_NOR = 3'b100;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EX_R, S_EX_ADDR, S_EX_BEQ, S_EX_BNE,
    S_EX_JMP, S_R_DONE, S_MEM_RD, S_MEM_WR, S_LD_DONE, S_HALT
  } state_t;

  state_t state, state_nx;
  logic [2:0] funct_op;
  logic mem_wr_raw, ir_wr_raw, pc_wr_raw, pc_wr_cond_raw, reg_wr_raw;
  logic in_halt;

  assign in_halt = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= state_nx;
  end

  always_comb begin
    unique case (funct)
      6'h20:   funct_op = ALU_ADD;
      6'h22:   funct_op = ALU_SUB;
      6'h24:   funct_op = ALU_AND;
      6'h25:   funct_op = ALU_OR;
      6'h27:   funct_op = ALU_NOR;
      6'h2A:   funct_op = ALU_SLT;
      default: funct_op = ALU_ADD;
    endcase
  end

  always_comb begin
    state_nx = S_FETCH;
    case (state)
      S_FETCH:  state_nx = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OP_RTYPE: state_nx = S_EX_R;
          OP_LOAD,
          OP_STORE: state_nx = S_EX_ADDR;
          OP_BEQ:   state_nx = S_EX_BEQ;
          OP_BNE:   state_nx = S_EX_BNE;
          OP_JUMP:  state_nx = S_EX_JMP;
          OP_HALT:  state_nx = S_HALT;
          default:  state_nx = S_FETCH;
        endcase
      end
      S_EX_R:    state_nx = S_R_DONE;
      S_EX_ADDR: state_nx = (opcode == OP_LOAD) ? S_MEM_RD : S_MEM_WR;
      S_MEM_RD:  state_nx = S_LD_DONE;
      S_HALT:    state_nx = S_HALT;
      default:   state_nx = S_FETCH;
    endcase
  end

  always_comb begin
    addr_sel       = 1'b0;
    mem_rd         = 1'b0;
    mem_wr_raw     = 1'b0;
    ir_wr_raw      = 1'b0;
    pc_wr_raw      = 1'b0;
    pc_wr_cond_raw = 1'b0;
    br_ne          = 1'b0;
    alu_a_sel      = 1'b0;
    alu_b_sel      = 2'b00;
    alu_op         = ALU_ADD;
    dst_sel        = 1'b0;
    wb_sel         = 1'b0;
    reg_wr_raw     = 1'b0;
    pc_src         = 2'b00;
    case (state)
      S_FETCH: begin
        mem_rd    = 1'b1;
        ir_wr_raw = 1'b1;
        alu_b_sel = 2'b01;
        pc_wr_raw = 1'b1;
      end
      S_DECODE: alu_b_sel = 2'b11;
      S_EX_R: begin
        alu_a_sel = 1'b1;
        alu_op    = funct_op;
      end
      S_R_DONE: begin
        alu_a_sel  = 1'b1;
        alu_op     = funct_op;
        dst_sel    = 1'b1;
        reg_wr_raw = 1'b1;
      end
      S_EX_ADDR: begin
        alu_a_sel = 1'b1;
        alu_b_sel = 2'b10;
      end
      S_MEM_RD: begin
        addr_sel = 1'b1;
        mem_rd   = 1'b1;
      end
      S_MEM_WR: begin
        addr_sel   = 1'b1;
        mem_wr_raw = 1'b1;
      end
      S_LD_DONE: begin
        wb_sel     = 1'b1;
        reg_wr_raw = 1'b1;
      end
      S_EX_BEQ, S_EX_BNE: begin
        alu_a_sel      = 1'b1;
        alu_op         = ALU_SUB;
        pc_wr_cond_raw = 1'b1;
        br_ne          = (state == S_EX_BNE);
        pc_src         = 2'b01;
      end
      S_EX_JMP: begin
        pc_wr_raw = 1'b1;
        pc_src    = 2'b10;
      end
      default: ;
    endcase
  end

  assign mem_wr     = mem_wr_raw     & ~rst;
  assign ir_wr      = ir_wr_raw      & ~rst;
  assign pc_wr      = pc_wr_raw      & ~rst;
  assign pc_wr_cond = pc_wr_cond_raw & ~rst;
  assign reg_wr     = reg_wr_raw     & ~rst;

endmodule

// File: rtl/mcyc_control_chk.sv
module mcyc_control_chk (
  input logic       clk,
  input logic       rst,
  input logic       addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_wr,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       reg_wr,
  input logic       in_halt
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> !(mem_wr || ir_wr || pc_wr || pc_wr_cond || reg_wr)); // R11

  AST_FETCH_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    ir_wr |-> (mem_rd && !addr_sel && pc_wr)); // R1

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> !(ir_wr || mem_rd || mem_wr || pc_wr || pc_wr_cond || reg_wr)); // R2

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R6

  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (addr_sel && !reg_wr) ##1 ir_wr); // R6

  AST_REGWR_ENDS: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> ir_wr); // R3

  AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_wr); // R7

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    in_halt |=> in_halt); // R10

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    in_halt |-> !(mem_rd || mem_wr || ir_wr || pc_wr || pc_wr_cond || reg_wr)); // R10

endmodule

bind mcyc_control mcyc_control_chk u_chk (
  .clk(clk), .rst(rst), .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .ir_wr(ir_wr), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .reg_wr(reg_wr),
  .in_halt(in_halt)
);

// File: tb/mcyc_control_bench.sv
`timescale 1ns/1ps
module mcyc_control_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic addr_sel, mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, br_ne;
  logic alu_a_sel, dst_sel, wb_sel, reg_wr;
  logic [1:0] alu_b_sel, pc_src;
  logic [2:0] alu_op;

  always #2.5 clk = ~clk;

  mcyc_control u_mcyc_control (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .br_ne(br_ne),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .reg_wr(reg_wr), .pc_src(pc_src)
  );

  typedef struct {
    logic [17:0] v;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_AND = 3'b000, A_OR = 3'b001, A_ADD = 3'b010;
  localparam logic [2:0] A_NOR = 3'b100, A_SUB = 3'b110, A_SLT = 3'b111;

  // field order: addr_sel mem_rd mem_wr ir_wr pc_wr pc_wr_cond br_ne a_sel b_sel alu_op dst wb reg_wr pc_src
  function automatic logic [17:0] pk(logic ad, logic rd, logic wr, logic ir, logic pw,
      logic pc, logic ne, logic as, logic [1:0] bs, logic [2:0] op,
      logic ds, logic wb, logic rw, logic [1:0] ps);
    return {ad, rd, wr, ir, pw, pc, ne, as, bs, op, ds, wb, rw, ps};
  endfunction

  function automatic logic [17:0] v_fetch();  return pk(0,1,0,1,1,0,0,0,2'b01,A_ADD,0,0,0,2'b00); endfunction
  function automatic logic [17:0] v_rstq();   return pk(0,1,0,0,0,0,0,0,2'b01,A_ADD,0,0,0,2'b00); endfunction
  function automatic logic [17:0] v_decode(); return pk(0,0,0,0,0,0,0,0,2'b11,A_ADD,0,0,0,2'b00); endfunction
  function automatic logic [17:0] v_idle();   return pk(0,0,0,0,0,0,0,0,2'b00,A_ADD,0,0,0,2'b00); endfunction

  function automatic logic [17:0] cur();
    return {addr_sel, mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, br_ne, alu_a_sel,
            alu_b_sel, alu_op, dst_sel, wb_sel, reg_wr, pc_src};
  endfunction

  task automatic step(input logic r, input logic [5:0] op, input logic [5:0] fn,
                      input logic [17:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    rst = r; opcode = op; funct = fn;
    it.v = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(1'b1, 6'h3F, 6'h00, v_rstq(), "R11");
  endtask

  task automatic head(input logic [5:0] op, input logic [5:0] fn, input string tag);
    step(1'b0, op, fn, v_fetch(), {"R1/", tag});
    step(1'b0, op, fn, v_decode(), {"R2/", tag});
  endtask

  task automatic rtype(input logic [5:0] fn, input logic [5:0] fn2,
                       input logic [2:0] e1, input logic [2:0] e2);
    head(6'b000000, fn, "R3");
    step(1'b0, 6'b000000, fn, pk(0,0,0,0,0,0,0,1,2'b00,e1,0,0,0,2'b00), "R3 exec");
    step(1'b0, 6'b000000, fn2, pk(0,0,0,0,0,0,0,1,2'b00,e2,1,0,1,2'b00), "R3 done");
  endtask

  always begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      n_vec++;
      if (cur() !== it.v) begin
        n_bad++;
        $display("FAIL %s at %0t: actual %b expected %b", it.tag, $time, cur(), it.v);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual hung, expected completion");
      summary();
    end
  end

  initial begin
    rst = 1'b1;
    repeat (2) @(negedge clk);
    do_reset();
    // R3: all six function codes, and a function change between steps
    rtype(6'h20, 6'h20, A_ADD, A_ADD);
    rtype(6'h22, 6'h22, A_SUB, A_SUB);
    rtype(6'h24, 6'h24, A_AND, A_AND);
    rtype(6'h25, 6'h25, A_OR,  A_OR);
    rtype(6'h27, 6'h27, A_NOR, A_NOR);
    rtype(6'h2A, 6'h22, A_SLT, A_SUB);
    // R4, R5: load
    head(6'b100011, 6'h00, "R5");
    step(0, 6'b100011, 6'h00, pk(0,0,0,0,0,0,0,1,2'b10,A_ADD,0,0,0,2'b00), "R4 load addr");
    step(0, 6'b100011, 6'h00, pk(1,1,0,0,0,0,0,0,2'b00,A_ADD,0,0,0,2'b00), "R5 read");
    step(0, 6'b100011, 6'h00, pk(0,0,0,0,0,0,0,0,2'b00,A_ADD,0,1,1,2'b00), "R5 writeback");
    // R4, R6: store
    head(6'b101011, 6'h00, "R6");
    step(0, 6'b101011, 6'h00, pk(0,0,0,0,0,0,0,1,2'b10,A_ADD,0,0,0,2'b00), "R4 store addr");
    step(0, 6'b101011, 6'h00, pk(1,0,1,0,0,0,0,0,2'b00,A_ADD,0,0,0,2'b00), "R6 write");
    // R7 / R8 branches
    head(6'b000100, 6'h00, "R7");
    step(0, 6'b000100, 6'h00, pk(0,0,0,0,0,1,0,1,2'b00,A_SUB,0,0,0,2'b01), "R7 beq");
    head(6'b000101, 6'h00, "R8");
    step(0, 6'b000101, 6'h00, pk(0,0,0,0,0,1,1,1,2'b00,A_SUB,0,0,0,2'b01), "R8 bne");
    // R9 jump
    head(6'b000010, 6'h00, "R9");
    step(0, 6'b000010, 6'h00, pk(0,0,0,0,1,0,0,0,2'b00,A_ADD,0,0,0,2'b10), "R9 jump");
    // R12 unknown opcode goes straight back to fetch
    head(6'b001000, 6'h00, "R12");
    head(6'b111110, 6'h20, "R12 back to fetch");
    // R11 reset mid-instruction
    head(6'b100011, 6'h00, "R11 pre");
    do_reset();
    head(6'b000010, 6'h00, "R11 after reset");
    step(0, 6'b000010, 6'h00, pk(0,0,0,0,1,0,0,0,2'b00,A_ADD,0,0,0,2'b10), "R11 jump after reset");
    // R10 halt: stays quiet whatever the inputs do
    head(6'b111111, 6'h00, "R10");
    for (int i = 0; i < 64; i++) begin
      logic [5:0] ops[7] = '{6'h00, 6'h23, 6'h2B, 6'h04, 6'h05, 6'h02, 6'h3F};
      step(0, ops[i % 7], 6'(6'h20 + i % 11), v_idle(), "R10 halt");
    end
    do_reset();
    rtype(6'h25, 6'h25, A_OR, A_OR);
    repeat (2) @(negedge clk);
    #2;
    done = 1'b1;
    summary();
  end

endmodule